// File: doc/BRIEF.md
# Receive Error Counters With Write-Clear

This block keeps two receive error tallies for a line receiver. One counts checksum (CRC) failures and the other counts block errors that the far end reports back. A one-cycle pulse on an event input adds one to the matching tally. Each tally stops at its largest value instead of wrapping. If another event arrives while a tally is already full, that tally's overflow bit is set and stays set.

The same register space holds a status word. It carries the two overflow bits and three other sticky receive flags: a per-frame checksum flag, a FIFO error flag and a rate-stuffing error flag. Software clears the tallies through a dedicated clear address, and the write data is ignored. That write zeroes both tallies and both overflow bits on the next clock edge and leaves the three other flags alone. Those three flags are cleared only by writing ones to their bit positions in the status word.

Reads are combinational from the read address. The tallies are zero-extended to the data width.

Top module: `rxerr_counters`

## Requirements
- R1: After system reset, every readable address returns 0.
- R2: Each clock with `crc_ev` high raises the tally read at address 0 by one, unless the tally is at its maximum.
- R3: Each clock with `febe_ev` high raises the tally read at address 1 by one, unless it is at its maximum. The two tallies never affect each other.
- R4: A tally at its maximum (2^CNT_W-1) stays there when further events arrive. It does not wrap.
- R5: An event that arrives while its tally is at maximum sets that tally's overflow bit in the status word at address 2: bit 0 for CRC, bit 1 for far-end. The bit stays set until a clear-register write or system reset.
- R6: A write of any data to address 3 sets both tallies and both overflow bits to 0 from the next clock edge.
- R7: If an event and a clear-register write fall in the same cycle, the clear wins. The tally reads 0 and its overflow bit is 0 afterwards.
- R8: A clear-register write leaves status bits 2 (frame checksum flag), 3 (FIFO error flag) and 4 (stuffing error flag) unchanged.
- R9: A pulse on `frm_crc_ev`, `fifo_ev` or `stuff_ev` sets status bit 2, 3 or 4 respectively, and that bit stays set.
- R10: A write to address 2 clears those of status bits 2 to 4 that are written as 1. It leaves bits 0 and 1 unchanged. A flag event in the same cycle wins over the clear.
- R11: A read of any other address returns 0. A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| crc_ev | input | 1 | CRC error event pulse |
| febe_ev | input | 1 | Far-end block error event pulse |
| frm_crc_ev | input | 1 | Per-frame checksum flag event |
| fifo_ev | input | 1 | FIFO error flag event |
| stuff_ev | input | 1 | Stuffing error flag event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Register read data |

## Verification
The bench builds the block with CNT_W = 4, so a tally is full after 15 events. At that width, every tally value from 0 up through several events past saturation is swept for both counters, including the overflow transition. The default 8-bit width would need 255 events per sweep for the same coverage. Keeping DATA_W at 8 also exercises zero-extension of the narrow tally on reads.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;
    // status word bit positions (software decodes these)
    localparam int ST_CRC_OVR  = 0;
    localparam int ST_FEBE_OVR = 1;
    localparam int ST_FRM_CRC  = 2;
    localparam int ST_FIFO     = 3;
    localparam int ST_STUFF    = 4;
    localparam int ST_BITS     = 5;

    localparam int NUM_CNT     = 2;  // tally index 0: CRC, 1: far-end
    localparam int NUM_FLAG    = 3;  // frame crc, fifo, stuffing
endpackage

// File: rtl/rxerr_sat_cnt.sv
module rxerr_sat_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             ovr
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovr;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (inc) begin
            if (st_q.cnt == CNT_MAX) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign ovr = st_q.ovr;
endmodule

// File: rtl/rxerr_sticky.sv
module rxerr_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] w1c,
    output logic [N-1:0] flags
);
    typedef struct packed {
        logic [N-1:0] flags;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a fresh event outranks a simultaneous software clear
        st_d.flags = (st_q.flags & ~w1c) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;
endmodule

// File: rtl/rxerr_regif.sv
module rxerr_regif
    import rxerr_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter int                DATA_W   = 8,
    parameter int                CNT_W    = 8,
    parameter logic [ADDR_W-1:0] ADR_CRC  = 0,
    parameter logic [ADDR_W-1:0] ADR_FEBE = 1,
    parameter logic [ADDR_W-1:0] ADR_STAT = 2,
    parameter logic [ADDR_W-1:0] ADR_CLR  = 3
) (
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt,
    input  logic [NUM_CNT-1:0]            ovr,
    input  logic [NUM_FLAG-1:0]           flags,
    output logic                          cnt_clr,
    output logic [NUM_FLAG-1:0]           flag_w1c,
    output logic [DATA_W-1:0]             rd_data
);
    logic [ST_BITS-1:0] status;

    assign status = {flags, ovr};

    always_comb begin
        cnt_clr  = wr_en && (wr_addr == ADR_CLR);
        flag_w1c = '0;
        if (wr_en && (wr_addr == ADR_STAT)) begin
            flag_w1c = wr_data[ST_FRM_CRC +: NUM_FLAG];
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADR_CRC:  rd_data = DATA_W'(cnt[0]);
            ADR_FEBE: rd_data = DATA_W'(cnt[1]);
            ADR_STAT: rd_data = DATA_W'(status);
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rxerr_counters.sv
module rxerr_counters
    import rxerr_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter int                DATA_W   = 8,
    parameter int                CNT_W    = 8,
    parameter logic [ADDR_W-1:0] ADR_CRC  = 0,
    parameter logic [ADDR_W-1:0] ADR_FEBE = 1,
    parameter logic [ADDR_W-1:0] ADR_STAT = 2,
    parameter logic [ADDR_W-1:0] ADR_CLR  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crc_ev,
    input  logic              febe_ev,
    input  logic              frm_crc_ev,
    input  logic              fifo_ev,
    input  logic              stuff_ev,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
    logic [NUM_CNT-1:0]            ovr;
    logic [NUM_CNT-1:0]            cnt_ev;
    logic [NUM_FLAG-1:0]           flags;
    logic [NUM_FLAG-1:0]           flag_ev;
    logic [NUM_FLAG-1:0]           flag_w1c;
    logic                          cnt_clr;

    assign cnt_ev  = {febe_ev, crc_ev};
    assign flag_ev = {stuff_ev, fifo_ev, frm_crc_ev};

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        rxerr_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cnt_ev[i]),
            .clr   (cnt_clr),
            .cnt   (cnt[i]),
            .ovr   (ovr[i])
        );
    end

    rxerr_sticky #(.N(NUM_FLAG)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_ev),
        .w1c   (flag_w1c),
        .flags (flags)
    );

    rxerr_regif #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CNT_W    (CNT_W),
        .ADR_CRC  (ADR_CRC),
        .ADR_FEBE (ADR_FEBE),
        .ADR_STAT (ADR_STAT),
        .ADR_CLR  (ADR_CLR)
    ) u_regif (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .cnt      (cnt),
        .ovr      (ovr),
        .flags    (flags),
        .cnt_clr  (cnt_clr),
        .flag_w1c (flag_w1c),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/rxerr_counters_chk.sv
module rxerr_counters_chk
    import rxerr_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter int                CNT_W    = 8,
    parameter logic [ADDR_W-1:0] ADR_STAT = 2,
    parameter logic [ADDR_W-1:0] ADR_CLR  = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          crc_ev,
    input logic                          febe_ev,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt,
    input logic [NUM_CNT-1:0]            ovr,
    input logic [NUM_FLAG-1:0]           flags
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic clr_wr, stat_wr;
    assign clr_wr  = wr_en && (wr_addr == ADR_CLR);
    assign stat_wr = wr_en && (wr_addr == ADR_STAT);

    a_r2_crc_step: assert property (@(posedge clk) disable iff (!rst_n)
        crc_ev && !clr_wr && cnt[0] != CNT_MAX |=> cnt[0] == $past(cnt[0]) + CNT_W'(1));

    a_r3_febe_step: assert property (@(posedge clk) disable iff (!rst_n)
        febe_ev && !clr_wr && cnt[1] != CNT_MAX |=> cnt[1] == $past(cnt[1]) + CNT_W'(1));

    a_r4_crc_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
        cnt[0] == CNT_MAX && !clr_wr |=> cnt[0] == CNT_MAX);

    a_r5_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovr[0] && !clr_wr |=> ovr[0]);

    a_r5_ovr_sets: assert property (@(posedge clk) disable iff (!rst_n)
        crc_ev && !clr_wr && cnt[0] == CNT_MAX |=> ovr[0]);

    a_r6_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> cnt == '0 && ovr == '0);

    a_r8_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && !stat_wr |=> (flags & $past(flags)) == $past(flags));
endmodule

bind rxerr_counters rxerr_counters_chk #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .ADR_STAT (ADR_STAT),
    .ADR_CLR  (ADR_CLR)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .crc_ev  (crc_ev),
    .febe_ev (febe_ev),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .cnt     (cnt),
    .ovr     (ovr),
    .flags   (flags)
);

// File: tb/rxerr_counters_tb.sv
module rxerr_counters_tb;
    localparam int CW  = 4;
    localparam int MX  = (1 << CW) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       crc_ev = 0, febe_ev = 0, frm_crc_ev = 0, fifo_ev = 0, stuff_ev = 0;
    logic       wr_en = 0;
    logic [3:0] wr_addr = 0, rd_addr = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;

    int n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    rxerr_counters #(.ADDR_W(4), .DATA_W(8), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .crc_ev(crc_ev), .febe_ev(febe_ev),
        .frm_crc_ev(frm_crc_ev), .fifo_ev(fifo_ev), .stuff_ev(stuff_ev),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data));

    // ev bits: 0 crc, 1 febe, 2 frame crc, 3 fifo, 4 stuffing
    task automatic cyc(input logic [4:0] ev, input logic we,
                       input logic [3:0] wa, input logic [7:0] wd);
        {stuff_ev, fifo_ev, frm_crc_ev, febe_ev, crc_ev} = ev;
        wr_en = we; wr_addr = wa; wr_data = wd;
        @(posedge clk);
        @(negedge clk);
        {stuff_ev, fifo_ev, frm_crc_ev, febe_ev, crc_ev} = '0;
        wr_en = 0; wr_addr = 0; wr_data = 0;
    endtask

    task automatic chk(input string req, input logic [3:0] a, input int exp);
        rd_addr = a;
        #1;
        n_run++;
        if (int'(rd_data) != exp) begin
            n_fail++;
            $display("FAIL %s addr %0d: got %0d expected %0d", req, a, rd_data, exp);
        end
    endtask

    task automatic wipe();
        cyc(5'b0, 1'b1, 4'd3, 8'hA5);
        cyc(5'b0, 1'b1, 4'd2, 8'h1C);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 16; a++) chk("R1", 4'(a), 0);

        // R2/R4/R5 sweep on CRC tally, far-end idle (R3 independence)
        for (int n = 0; n <= MX + 4; n++) begin
            wipe();
            for (int k = 0; k < n; k++) cyc(5'b00001, 0, 0, 0);
            chk("R2_R4", 4'd0, (n > MX) ? MX : n);
            chk("R3", 4'd1, 0);
            chk("R5", 4'd2, (n > MX) ? 1 : 0);
        end
        // same sweep on the far-end tally
        for (int n = 0; n <= MX + 4; n++) begin
            wipe();
            for (int k = 0; k < n; k++) cyc(5'b00010, 0, 0, 0);
            chk("R3_R4", 4'd1, (n > MX) ? MX : n);
            chk("R3", 4'd0, 0);
            chk("R5", 4'd2, (n > MX) ? 2 : 0);
        end
        // interleaved: both together, then crc only
        wipe();
        for (int k = 0; k < 7; k++) cyc(5'b00011, 0, 0, 0);
        for (int k = 0; k < 3; k++) cyc(5'b00001, 0, 0, 0);
        chk("R2", 4'd0, 10);
        chk("R3", 4'd1, 7);

        // R5 sticky after further events and status writes
        wipe();
        for (int k = 0; k < MX + 1; k++) cyc(5'b00001, 0, 0, 0);
        cyc(5'b0, 1'b1, 4'd2, 8'hFF);
        chk("R5_R10", 4'd2, 1);

        // R6 clear with various data values
        for (int d = 0; d < 256; d += 51) begin
            for (int k = 0; k < MX + 2; k++) cyc(5'b00011, 0, 0, 0);
            cyc(5'b0, 1'b1, 4'd3, 8'(d));
            chk("R6", 4'd0, 0);
            chk("R6", 4'd1, 0);
            chk("R6", 4'd2, 0);
        end

        // R7 coincident event and clear
        wipe();
        for (int k = 0; k < 5; k++) cyc(5'b00011, 0, 0, 0);
        cyc(5'b00011, 1'b1, 4'd3, 8'h00);
        chk("R7", 4'd0, 0);
        chk("R7", 4'd1, 0);
        for (int k = 0; k < MX; k++) cyc(5'b00001, 0, 0, 0);
        cyc(5'b00001, 1'b1, 4'd3, 8'h00);
        chk("R7", 4'd2, 0);
        chk("R7", 4'd0, 0);

        // R9 flag events, R8 clear write keeps them
        wipe();
        cyc(5'b00100, 0, 0, 0);
        chk("R9", 4'd2, 4);
        cyc(5'b01000, 0, 0, 0);
        cyc(5'b10000, 0, 0, 0);
        chk("R9", 4'd2, 28);
        cyc(5'b0, 1'b1, 4'd3, 8'hFF);
        chk("R8", 4'd2, 28);

        // R10 selective write-one-to-clear, event beats clear
        cyc(5'b0, 1'b1, 4'd2, 8'h08);
        chk("R10", 4'd2, 20);
        cyc(5'b00100, 1'b1, 4'd2, 8'h04);
        chk("R10", 4'd2, 20);
        cyc(5'b0, 1'b1, 4'd2, 8'h14);
        chk("R10", 4'd2, 0);

        // R11 unmapped write has no effect
        for (int k = 0; k < 3; k++) cyc(5'b00011, 0, 0, 0);
        cyc(5'b00100, 0, 0, 0);
        for (int a = 4; a < 16; a++) cyc(5'b0, 1'b1, 4'(a), 8'hFF);
        chk("R11", 4'd0, 3);
        chk("R11", 4'd1, 3);
        chk("R11", 4'd2, 4);
        for (int a = 4; a < 16; a++) chk("R11", 4'(a), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule